// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block runs on the processor side once the priority arbiter has accepted an interrupt. It waits for the next instruction to reach the decode stage. It then throws that instruction away and starts the entry sequence.

The sequence has a fixed order:

1. Two 32-bit pushes through a shared memory port: first the status word, then the address of the discarded instruction. The stack pointer is pre-decremented by one word before each push.
2. One cycle that writes the new stack pointer back and raises the status word's mask field to the accepted level.
3. A table read at vector base plus four times the vector number. The vector number comes either from the internal assignment or from an external 8-bit bus.
4. A one-cycle program-counter load with the fetched handler address. No delay slot follows it.

Every memory access uses a request/ready handshake. The sequencer holds its request until ready is seen, so any number of wait states is absorbed. Datapath width, vector width and the position and width of the mask field are parameters. A parameter can also remove the external vector path altogether.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `mem_req`, `pc_load`, `sp_wr_en` and `sr_wr_en` are all 0.
- R2: While idle, `dec_cancel` is 1 in exactly the cycle where `dec_valid` and `irq_accept` are both 1, and the sequencer is busy from the next cycle. When only one of the two inputs is high, nothing starts.
- R3: The first memory access writes the captured status word to address SP-4. The second writes the captured `dec_pc` to address SP-8, where SP is `sp_in` at the start cycle.
- R4: Each access holds `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle with `mem_ready` high. Each of the three accesses occurs exactly once, whatever the number of wait states.
- R5: In the single cycle after the second push, `sp_wr_en` and `sr_wr_en` are both 1. At that point `sp_wr_data` is SP-8. `sr_wr_data` is the captured status word with bits [7:4] (the mask field at default parameters) replaced by `irq_level`, and all other bits unchanged.
- R6: The vector number is `ext_vec_bus` when both `irq_ext` and `ext_vec_mode` are 1, and is `irq_int_vec` otherwise.
- R7: The third access is a read (`mem_we`=0) at address `vbr` + 4 × vector number.
- R8: One cycle after the read completes, `pc_load` is 1 for exactly one cycle, with `pc_target` equal to the read data. In the following cycle `busy` is 0 and no memory access occurs in between.
- R9: While busy, `dec_cancel` stays 0 whatever `dec_valid` and `irq_accept` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_accept | input | 1 | Arbiter has an accepted interrupt waiting |
| irq_level | input | 4 | Level of the accepted interrupt |
| irq_int_vec | input | 8 | Internally assigned vector number |
| irq_ext | input | 1 | Accepted interrupt comes from an external pin |
| ext_vec_mode | input | 1 | External vector mode enable |
| ext_vec_bus | input | 8 | External vector number input |
| dec_valid | input | 1 | An instruction is at the decode boundary |
| dec_pc | input | 32 | Address of the decoded instruction |
| sr_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| vbr | input | 32 | Vector table base |
| dec_cancel | output | 1 | Discard the decoded instruction |
| busy | output | 1 | Entry sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| sp_wr_en | output | 1 | Write back stack pointer |
| sp_wr_data | output | 32 | New stack pointer |
| sr_wr_en | output | 1 | Write back status word |
| sr_wr_data | output | 32 | New status word |
| pc_load | output | 1 | Redirect program counter |
| pc_target | output | 32 | Handler address |

## Verification
The assertions assume a memory side that raises `mem_ready` only while `mem_req` is high. They also assume the core holds `dec_pc`, `sr_in`, `sp_in` and `vbr` steady for the cycle in which the sequence starts. The stimulus gives the memory model a wait-state count from zero to two. That model asserts ready only in response to a request and drops it after each completed access. The stimulus also holds `dec_valid` and `irq_accept` high throughout each sequence, to test that they are ignored, and drops them in the cycle `pc_load` appears so that no second entry follows. `ext_vec_bus` stays constant within a run, so sampling it at any cycle of the sequence gives the expected vector.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_SR = 3'd1,
      ST_PUSH_PC = 3'd2,
      ST_MASK    = 3'd3,
      ST_FETCH   = 3'd4,
      ST_JUMP    = 3'd5
   } entry_st_e;
endpackage

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
   parameter int VEC_W      = 8,
   parameter bit EXT_VEC_EN = 1'b1
) (
   input  logic [VEC_W-1:0] int_vec,
   input  logic [VEC_W-1:0] ext_vec,
   input  logic             use_ext,
   output logic [VEC_W-1:0] vec
);
   generate
      if (EXT_VEC_EN) begin : g_ext
         assign vec = use_ext ? ext_vec : int_vec;
      end else begin : g_int_only
         logic unused_ext;
         assign unused_ext = use_ext ^ (^ext_vec);
         assign vec = int_vec;
      end
   endgenerate
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int XLEN  = 32,
   parameter int VEC_W = 8
) (
   input  logic [XLEN-1:0]  base,
   input  logic [VEC_W-1:0] vec,
   output logic [XLEN-1:0]  entry_addr
);
   localparam int WORD_BYTES = XLEN / 8;
   localparam int SHIFT      = $clog2(WORD_BYTES);

   assign entry_addr = base + (XLEN'(vec) << SHIFT);
endmodule

// File: rtl/irq_sp_step.sv
module irq_sp_step #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] sp_cur,
   output logic [XLEN-1:0] sp_next
);
   localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

   assign sp_next = sp_cur - WORD_BYTES;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int XLEN       = 32,
   parameter int VEC_W      = 8,
   parameter int LVL_W      = 4,
   parameter int MASK_LSB   = 4,
   parameter bit EXT_VEC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_accept,
   input  logic [LVL_W-1:0] irq_level,
   input  logic [VEC_W-1:0] irq_int_vec,
   input  logic             irq_ext,
   input  logic             ext_vec_mode,
   input  logic [VEC_W-1:0] ext_vec_bus,
   input  logic             dec_valid,
   input  logic [XLEN-1:0]  dec_pc,
   input  logic [XLEN-1:0]  sr_in,
   input  logic [XLEN-1:0]  sp_in,
   input  logic [XLEN-1:0]  vbr,
   output logic             dec_cancel,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic             mem_ready,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             sp_wr_en,
   output logic [XLEN-1:0]  sp_wr_data,
   output logic             sr_wr_en,
   output logic [XLEN-1:0]  sr_wr_data,
   output logic             pc_load,
   output logic [XLEN-1:0]  pc_target
);
   import irq_entry_pkg::*;

   generate
      if (XLEN % 8 != 0 || XLEN < 16) begin : g_bad_xlen
         $error("irq_entry_seq: XLEN must be a byte multiple of at least 16");
      end
      if (MASK_LSB + LVL_W > XLEN) begin : g_bad_mask
         $error("irq_entry_seq: mask field exceeds status word");
      end
      if (VEC_W + $clog2(XLEN / 8) > XLEN) begin : g_bad_vec
         $error("irq_entry_seq: vector offset exceeds address width");
      end
   endgenerate

   entry_st_e        state_q, state_d;
   logic [XLEN-1:0]  pc_q, sr_q, sp_q, tgt_q;
   logic [LVL_W-1:0] lvl_q;
   logic [VEC_W-1:0] int_vec_q, vec_q, vec_pick;
   logic             use_ext_q;
   logic [XLEN-1:0]  sp_dec, tbl_addr;
   logic             start;

   irq_sp_step #(.XLEN(XLEN)) u_sp_step (
      .sp_cur  (sp_q),
      .sp_next (sp_dec)
   );

   irq_vec_sel #(.VEC_W(VEC_W), .EXT_VEC_EN(EXT_VEC_EN)) u_vec_sel (
      .int_vec (int_vec_q),
      .ext_vec (ext_vec_bus),
      .use_ext (use_ext_q),
      .vec     (vec_pick)
   );

   irq_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vec_addr (
      .base       (vbr),
      .vec        (vec_q),
      .entry_addr (tbl_addr)
   );

   assign start = (state_q == ST_IDLE) && dec_valid && irq_accept;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start) state_d = ST_PUSH_SR;
         ST_PUSH_SR: if (mem_ready) state_d = ST_PUSH_PC;
         ST_PUSH_PC: if (mem_ready) state_d = ST_MASK;
         ST_MASK:    state_d = ST_FETCH;
         ST_FETCH:   if (mem_ready) state_d = ST_JUMP;
         ST_JUMP:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pc_q      <= '0;
         sr_q      <= '0;
         sp_q      <= '0;
         tgt_q     <= '0;
         lvl_q     <= '0;
         int_vec_q <= '0;
         vec_q     <= '0;
         use_ext_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start) begin
            pc_q      <= dec_pc;
            sr_q      <= sr_in;
            sp_q      <= sp_in;
            lvl_q     <= irq_level;
            int_vec_q <= irq_int_vec;
            use_ext_q <= irq_ext && ext_vec_mode;
         end
         if ((state_q == ST_PUSH_SR || state_q == ST_PUSH_PC) && mem_ready) begin
            sp_q <= sp_dec;
         end
         if (state_q == ST_MASK) begin
            vec_q <= vec_pick;
         end
         if (state_q == ST_FETCH && mem_ready) begin
            tgt_q <= mem_rdata;
         end
      end
   end

   always_comb begin
      sr_wr_data = sr_q;
      sr_wr_data[MASK_LSB +: LVL_W] = lvl_q;
   end

   assign dec_cancel = start;
   assign busy       = (state_q != ST_IDLE);
   assign mem_req    = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC) ||
                       (state_q == ST_FETCH);
   assign mem_we     = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
   assign mem_addr   = (state_q == ST_FETCH) ? tbl_addr : sp_dec;
   assign mem_wdata  = (state_q == ST_PUSH_SR) ? sr_q : pc_q;
   assign sp_wr_en   = (state_q == ST_MASK);
   assign sp_wr_data = sp_q;
   assign sr_wr_en   = (state_q == ST_MASK);
   assign pc_load    = (state_q == ST_JUMP);
   assign pc_target  = tgt_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dec_valid,
   input logic            irq_accept,
   input logic            dec_cancel,
   input logic            busy,
   input logic            mem_req,
   input logic            mem_we,
   input logic [XLEN-1:0] mem_addr,
   input logic [XLEN-1:0] mem_wdata,
   input logic            mem_ready,
   input logic            pc_load,
   input logic            sr_wr_en
);
   // R1: idle means no memory traffic
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !pc_load && !sr_wr_en);

   // R2: a cancel only when both inputs are high, followed by busy
   assert_cancel_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_cancel |-> dec_valid && irq_accept ##1 busy);

   // R4: a pending access holds its command
   assert_hold_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

   // R8: single-cycle redirect, then idle
   assert_jump_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !pc_load && !busy);

   // R8: the redirect follows a completed read
   assert_jump_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pc_load) |-> $past(mem_req && mem_ready && !mem_we));

   // R9: no cancel while a sequence is running
   assert_no_cancel_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dec_cancel);
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN)) u_irq_entry_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_valid  (dec_valid),
   .irq_accept (irq_accept),
   .dec_cancel (dec_cancel),
   .busy       (busy),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ready  (mem_ready),
   .pc_load    (pc_load),
   .sr_wr_en   (sr_wr_en)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_accept = 1'b0;
   logic [3:0]  irq_level = '0;
   logic [7:0]  irq_int_vec = '0;
   logic        irq_ext = 1'b0;
   logic        ext_vec_mode = 1'b0;
   logic [7:0]  ext_vec_bus = '0;
   logic        dec_valid = 1'b0;
   logic [31:0] dec_pc = '0, sr_in = '0, sp_in = '0, vbr = '0;
   logic        dec_cancel, busy, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b0;
   logic        sp_wr_en, sr_wr_en, pc_load;
   logic [31:0] sp_wr_data, sr_wr_data, pc_target;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int wait_cfg = 0;
   int wcnt = 0;
   int lcnt = 0;
   logic [31:0] log_addr [0:7];
   logic [31:0] log_data [0:7];
   logic        log_we   [0:7];

   always #5 clk = ~clk;

   assign mem_rdata = ~mem_addr;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .irq_accept(irq_accept), .irq_level(irq_level),
      .irq_int_vec(irq_int_vec), .irq_ext(irq_ext), .ext_vec_mode(ext_vec_mode),
      .ext_vec_bus(ext_vec_bus), .dec_valid(dec_valid), .dec_pc(dec_pc),
      .sr_in(sr_in), .sp_in(sp_in), .vbr(vbr), .dec_cancel(dec_cancel),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sr_wr_en(sr_wr_en),
      .sr_wr_data(sr_wr_data), .pc_load(pc_load), .pc_target(pc_target)
   );

   // memory responder: ready after wait_cfg idle cycles, logs each completed access
   always @(negedge clk) begin
      if (mem_ready) begin
         mem_ready = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= wait_cfg) begin
            if (lcnt < 8) begin
               log_addr[lcnt] = mem_addr;
               log_data[lcnt] = mem_wdata;
               log_we[lcnt]   = mem_we;
            end
            lcnt = lcnt + 1;
            mem_ready = 1'b1;
         end else begin
            wcnt = wcnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
         end
      end
   end

   task automatic run_entry(input int lvl, input int src, input int wt);
      logic [31:0] exp_sr, exp_sp, exp_tgt, got_sr, got_sp, got_tgt, tbl;
      logic [7:0]  exp_vec;
      bit          seen_jump, seen_wb, bad_cancel;
      wait_cfg     = wt;
      irq_level    = 4'(lvl);
      irq_ext      = src[0];
      ext_vec_mode = src[1];
      irq_int_vec  = 8'(8'h40 + lvl * 3 + src);
      ext_vec_bus  = 8'(8'h80 + lvl * 5 + src);
      vbr          = 32'h0000_1000 + 32'(src) * 32'h100;
      sp_in        = 32'h0008_0000 - 32'(lvl) * 32'd16;
      dec_pc       = 32'h0000_2000 + 32'(lvl) * 32'd32 + 32'(src) * 32'd4;
      sr_in        = 32'hC0DE_0000 ^ (32'(lvl) * 32'h0101_0111) ^ 32'(src);
      exp_vec      = (src[0] && src[1]) ? ext_vec_bus : irq_int_vec;
      exp_sr       = (sr_in & ~32'h0000_00F0) | (32'(lvl) << 4);
      exp_sp       = sp_in - 32'd8;
      tbl          = vbr + 32'(exp_vec) * 32'd4;
      exp_tgt      = ~tbl;
      lcnt         = 0;
      got_sr = '0; got_sp = '0; got_tgt = '0;
      seen_jump = 1'b0; seen_wb = 1'b0; bad_cancel = 1'b0;
      dec_valid  = 1'b1;
      irq_accept = 1'b1;
      #1;
      chk(dec_cancel === 1'b1, "R2 cancel at decode", {31'b0, dec_cancel}, 32'd1);
      for (int c = 0; c < 80 && !seen_jump; c++) begin
         @(negedge clk);
         #1;
         if (dec_cancel !== 1'b0) bad_cancel = 1'b1;
         if (sp_wr_en && sr_wr_en) begin
            seen_wb = 1'b1;
            got_sp  = sp_wr_data;
            got_sr  = sr_wr_data;
         end
         if (pc_load) begin
            seen_jump  = 1'b1;
            got_tgt    = pc_target;
            dec_valid  = 1'b0;
            irq_accept = 1'b0;
         end
      end
      chk(!bad_cancel, "R9 no cancel while busy", {31'b0, bad_cancel}, 32'd0);
      chk(seen_jump, "R8 pc_load reached", {31'b0, seen_jump}, 32'd1);
      chk(got_tgt === exp_tgt, "R8 handler target", got_tgt, exp_tgt);
      chk(lcnt == 3, "R4 one completion per access", 32'(lcnt), 32'd3);
      chk(log_we[0] === 1'b1 && log_addr[0] === sp_in - 32'd4, "R3 SR push address",
          log_addr[0], sp_in - 32'd4);
      chk(log_data[0] === sr_in, "R3 SR push data", log_data[0], sr_in);
      chk(log_we[1] === 1'b1 && log_addr[1] === exp_sp, "R3 PC push address",
          log_addr[1], exp_sp);
      chk(log_data[1] === dec_pc, "R3 PC push data", log_data[1], dec_pc);
      chk(seen_wb, "R5 writeback cycle", {31'b0, seen_wb}, 32'd1);
      chk(got_sp === exp_sp, "R5 stack pointer", got_sp, exp_sp);
      chk(got_sr === exp_sr, "R5 mask raised", got_sr, exp_sr);
      chk(log_we[2] === 1'b0, "R7 table access is read", {31'b0, log_we[2]}, 32'd0);
      chk(log_addr[2] === tbl, "R6 R7 vector table address", log_addr[2], tbl);
      @(negedge clk);
      #1;
      chk(!busy && !pc_load && !mem_req, "R8 idle after jump",
          {29'b0, busy, pc_load, mem_req}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !mem_req && !pc_load && !sp_wr_en && !sr_wr_en, "R1 reset state",
          {27'b0, busy, mem_req, pc_load, sp_wr_en, sr_wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      irq_accept = 1'b1;
      dec_valid  = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk(!busy && !dec_cancel, "R2 no start without decode",
             {30'b0, busy, dec_cancel}, 32'd0);
      end
      irq_accept = 1'b0;
      dec_valid  = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk(!busy && !dec_cancel && !mem_req, "R2 no start without accept",
             {29'b0, busy, dec_cancel, mem_req}, 32'd0);
      end
      dec_valid = 1'b0;
      for (int lvl = 0; lvl < 16; lvl++) begin
         for (int src = 0; src < 4; src++) begin
            @(negedge clk);
            run_entry(lvl, src, (lvl + src) % 3);
         end
      end
      finish_run();
   end
endmodule